// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches recent page translations for an address pipeline. A 32-bit linear address splits into a 20-bit page number and a 12-bit byte offset. Four entries each hold a valid flag, a page-number key and a physical page number. Any entry may hold any key. On a lookup, the page number is compared with every stored key in parallel. A matching entry supplies the physical page number, and the offset is joined to it unchanged. The result is registered and appears one clock after the request.

After a miss, the page walker outside this block installs the missing mapping through the fill port. The fill goes to one of three places, in this order of preference:
- the entry that already holds the same key;
- otherwise the lowest-numbered empty entry;
- otherwise the entry named by a rotating replacement pointer.

Software pulses the flush input whenever the base of the translation tables changes. A flush empties the whole cache in one cycle.

Top module: `tlb_fa`

## Requirements
- R1: While reset is held and on the first cycle after it, `lk_hit` and `lk_paddr` are 0. After reset, every entry is empty, so every lookup misses.
- R2: The result of a lookup requested in cycle N appears on `lk_hit` and `lk_paddr` in cycle N+1. When no lookup was requested in cycle N, `lk_hit` is 0 in cycle N+1.
- R3: On a hit, `lk_paddr[31:12]` is the stored physical page number and `lk_paddr[11:0]` equals `lk_vaddr[11:0]` of the request.
- R4: On a miss, `lk_hit` is 0 and `lk_paddr` is 0.
- R5: Keys and values are arbitrary 20-bit numbers. Both all-ones and all-zeros are legal keys and values, and a value may equal another entry's key without ever matching as a key.
- R6: A fill of a new key while an entry is empty writes the lowest-numbered empty entry. No valid mapping is lost.
- R7: When all entries are valid, a fill of a new key replaces the entry named by the replacement pointer. The pointer starts at entry 0 and steps up by one, wrapping from 3 to 0, after each such replacement.
- R8: A fill whose key is already stored overwrites that entry's physical page number. No key is ever held twice, and the pointer does not move.
- R9: A flush empties all entries and returns the pointer to entry 0 at the next edge. A fill in the same cycle as a flush is discarded.
- R10: A lookup in the same cycle as a fill or flush sees the contents from before that fill or flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty all entries |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Linear address to translate |
| lk_hit | output | 1 | Registered lookup hit |
| lk_paddr | output | 32 | Registered physical address, 0 on miss |
| fill_en | input | 1 | Install a mapping |
| fill_vpn | input | 20 | Linear page number of the mapping |
| fill_ppn | input | 20 | Physical page number of the mapping |

## Verification
Each lookup result is due exactly one clock after its request. A fill or flush changes what lookups see from the following cycle onward.

The bench drives every input on a falling edge and holds it for one full cycle. It then reads the outputs at the next falling edge, which is half a cycle after the single register stage has loaded. This is exactly where the result of that one-cycle operation is due.

Fill-then-lookup sequences are built one cycle per operation. Same-cycle cases are driven together in one cycle, so the old-contents rule is observed directly at the output.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int unsigned VPN_W = 20;
    parameter int unsigned PPN_W = 20;
    parameter int unsigned OFS_W = 12;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int unsigned N = 4,
    parameter int unsigned W = 20
) (
    input  logic [N-1:0]   valid,
    input  logic [N*W-1:0] tags,
    input  logic [W-1:0]   key,
    output logic [N-1:0]   match
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g*W +: W] == key);
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int unsigned N     = 4,
    parameter int unsigned IDX_W = 2
) (
    input  logic [N-1:0]     valid,
    input  logic [N-1:0]     same_key,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic [IDX_W-1:0] idx,
    output logic             from_rr
);
    always_comb begin
        logic free_found;
        logic key_found;
        idx        = rr_ptr;
        free_found = 1'b0;
        key_found  = 1'b0;
        // lowest empty entry
        for (int i = int'(N) - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                idx        = IDX_W'(i);
                free_found = 1'b1;
            end
        end
        // an existing key beats everything
        for (int i = int'(N) - 1; i >= 0; i--) begin
            if (same_key[i]) begin
                idx       = IDX_W'(i);
                key_found = 1'b1;
            end
        end
        from_rr = !free_found && !key_found;
    end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   lk_req,
    input  logic [VPN_W+OFS_W-1:0] lk_vaddr,
    output logic                   lk_hit,
    output logic [PPN_W+OFS_W-1:0] lk_paddr,
    input  logic                   fill_en,
    input  logic [VPN_W-1:0]       fill_vpn,
    input  logic [PPN_W-1:0]       fill_ppn
);
    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int unsigned PA_W  = PPN_W + OFS_W;

    typedef struct packed {
        tlb_entry_t [ENTRIES-1:0] ent;
        logic [IDX_W-1:0]         rr;
        logic                     hit;
        logic [PA_W-1:0]          pa;
    } tlb_state_t;

    tlb_state_t st_d, st_q;

    logic [ENTRIES-1:0]       valid_vec;
    logic [ENTRIES*VPN_W-1:0] tag_flat;
    logic [ENTRIES-1:0]       lk_match;
    logic [ENTRIES-1:0]       fill_match;
    logic [IDX_W-1:0]         vic_idx;
    logic                     vic_rr;
    logic [PPN_W-1:0]         sel_ppn;

    always_comb begin
        for (int i = 0; i < int'(ENTRIES); i++) begin
            valid_vec[i]                = st_q.ent[i].valid;
            tag_flat[i*VPN_W +: VPN_W]  = st_q.ent[i].tag;
        end
    end

    tlb_match #(.N(ENTRIES), .W(VPN_W)) i_lk_match (
        .valid (valid_vec),
        .tags  (tag_flat),
        .key   (lk_vaddr[VPN_W+OFS_W-1:OFS_W]),
        .match (lk_match)
    );

    tlb_match #(.N(ENTRIES), .W(VPN_W)) i_fill_match (
        .valid (valid_vec),
        .tags  (tag_flat),
        .key   (fill_vpn),
        .match (fill_match)
    );

    tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) i_victim (
        .valid    (valid_vec),
        .same_key (fill_match),
        .rr_ptr   (st_q.rr),
        .idx      (vic_idx),
        .from_rr  (vic_rr)
    );

    always_comb begin
        sel_ppn = '0;
        for (int i = int'(ENTRIES) - 1; i >= 0; i--) begin
            if (lk_match[i]) sel_ppn = st_q.ent[i].ppn;
        end
    end

    always_comb begin
        st_d     = st_q;
        // lookup uses the current (old) contents
        st_d.hit = lk_req && (|lk_match);
        st_d.pa  = '0;
        if (st_d.hit) st_d.pa = {sel_ppn, lk_vaddr[OFS_W-1:0]};
        // contents update
        if (flush) begin
            for (int i = 0; i < int'(ENTRIES); i++) st_d.ent[i].valid = 1'b0;
            st_d.rr = '0;
        end else if (fill_en) begin
            st_d.ent[vic_idx].valid = 1'b1;
            st_d.ent[vic_idx].tag   = fill_vpn;
            st_d.ent[vic_idx].ppn   = fill_ppn;
            if (vic_rr) begin
                st_d.rr = (st_q.rr == IDX_W'(ENTRIES - 1)) ? '0 : st_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lk_hit   = st_q.hit;
    assign lk_paddr = st_q.pa;

    a_r2_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_hit);
    a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (!lk_hit || lk_paddr[OFS_W-1:0] == $past(lk_vaddr[OFS_W-1:0])));
    a_r4_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_paddr == '0));
    a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));
    a_r6_free_slot_used: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush && !(|fill_match) && !(&valid_vec)) |=>
        ($countones(valid_vec) == $countones($past(valid_vec)) + 1));
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));
endmodule

// File: tb/test_tlb_fa.sv
module test_tlb_fa;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit;
    logic [31:0] lk_paddr;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    tlb_fa i_tlb_fa (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_req(lk_req), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_paddr(lk_paddr),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn)
    );

    // {vaddr, expected hit, expected paddr}
    localparam logic [64:0] LK_VEC [8] = '{
        {32'h00000ABC, 1'b1, 32'h00001ABC},
        {32'h00001000, 1'b1, 32'h00010000},
        {32'h00010FFF, 1'b1, 32'h00011FFF},
        {32'hFFFFF7A5, 1'b1, 32'h000007A5},
        {32'h00002123, 1'b0, 32'h00000000},
        {32'h12345678, 1'b0, 32'h00000000},
        {32'hFFFFE000, 1'b0, 32'h00000000},
        {32'h00011000, 1'b0, 32'h00000000}
    };

    task automatic chk(input string req, input logic exp_hit, input logic [31:0] exp_pa);
        checks++;
        if (lk_hit !== exp_hit || lk_paddr !== exp_pa) begin
            fails++;
            $display("FAIL %s: hit=%0b paddr=%h expected hit=%0b paddr=%h",
                     req, lk_hit, lk_paddr, exp_hit, exp_pa);
        end
    endtask

    // one cycle of stimulus; returns at the falling edge where its result is due
    task automatic cyc(input logic f_en, input logic [19:0] vpn, input logic [19:0] ppn,
                       input logic l_en, input logic [31:0] va, input logic fl);
        @(negedge clk);
        fill_en = f_en; fill_vpn = vpn; fill_ppn = ppn;
        lk_req = l_en; lk_vaddr = va; flush = fl;
        @(negedge clk);
        fill_en = 1'b0; lk_req = 1'b0; flush = 1'b0;
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn);
        cyc(1'b1, vpn, ppn, 1'b0, '0, 1'b0);
    endtask

    task automatic look(input string req, input logic [31:0] va,
                        input logic exp_hit, input logic [31:0] exp_pa);
        cyc(1'b0, '0, '0, 1'b1, va, 1'b0);
        chk(req, exp_hit, exp_pa);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: hit=%0b paddr=%h expected run to end", lk_hit, lk_paddr);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        #22;
        chk("R1 in reset", 1'b0, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 1'b0, 32'h0);
        look("R1 empty miss", 32'h00000123, 1'b0, 32'h0);

        // R5 arbitrary mappings, table walk (R3, R4)
        fill(20'h00000, 20'h00001);
        fill(20'h00001, 20'h00010);
        fill(20'h00010, 20'h00011);
        fill(20'hFFFFF, 20'h00000);
        for (int k = 0; k < 8; k++) begin
            look(LK_VEC[k][0] ? "R5 R3 table hit" : "R4 R5 table miss",
                 LK_VEC[k][64:33], LK_VEC[k][32], LK_VEC[k][31:0]);
        end

        // R2 idle cycle gives no hit
        cyc(1'b0, '0, '0, 1'b0, 32'h00000ABC, 1'b0);
        chk("R2 no request", 1'b0, 32'h0);

        // R7 round-robin replacement from entry 0
        fill(20'h0ABCD, 20'h0DEAD);
        look("R7 entry0 evicted", 32'h00000000, 1'b0, 32'h0);
        look("R7 new mapping", 32'h0ABCD123, 1'b1, 32'h0DEAD123);
        fill(20'h0BEEF, 20'h0CAFE);
        look("R7 entry1 evicted", 32'h00001000, 1'b0, 32'h0);
        look("R7 entry2 kept", 32'h00010000, 1'b1, 32'h00011000);

        // R9 flush
        cyc(1'b0, '0, '0, 1'b0, '0, 1'b1);
        look("R9 flushed a", 32'hFFFFF000, 1'b0, 32'h0);
        look("R9 flushed b", 32'h0ABCD000, 1'b0, 32'h0);

        // R8 overwrite, R6 free slot first
        fill(20'h00100, 20'h00200);
        fill(20'h00101, 20'h00201);
        fill(20'h00102, 20'h00202);
        fill(20'h00100, 20'h00300);
        look("R8 overwritten value", 32'h00100044, 1'b1, 32'h00300044);
        fill(20'h00103, 20'h00203);
        fill(20'h00104, 20'h00204);
        look("R8 R6 entry0 replaced", 32'h00100000, 1'b0, 32'h0);
        look("R6 kept 00101", 32'h00101000, 1'b1, 32'h00201000);
        look("R6 kept 00103", 32'h00103000, 1'b1, 32'h00203000);
        look("R7 new 00104", 32'h00104000, 1'b1, 32'h00204000);

        // R10 same-cycle fill and lookup
        cyc(1'b0, '0, '0, 1'b0, '0, 1'b1);
        fill(20'h00500, 20'h00600);
        cyc(1'b1, 20'h00500, 20'h00700, 1'b1, 32'h00500321, 1'b0);
        chk("R10 old value seen", 1'b1, 32'h00600321);
        look("R10 new value after", 32'h00500321, 1'b1, 32'h00700321);
        cyc(1'b1, 20'h00501, 20'h00601, 1'b1, 32'h00501000, 1'b0);
        chk("R10 not yet installed", 1'b0, 32'h0);
        look("R10 installed after", 32'h00501000, 1'b1, 32'h00601000);

        // R9 flush beats fill, R10 lookup during flush sees old contents
        cyc(1'b1, 20'h00777, 20'h00888, 1'b1, 32'h00500000, 1'b1);
        chk("R10 lookup during flush", 1'b1, 32'h00700000);
        look("R9 fill dropped", 32'h00777000, 1'b0, 32'h0);
        look("R9 flushed entry", 32'h00500000, 1'b0, 32'h0);

        // R1 reset in mid-run
        fill(20'h00900, 20'h00901);
        cyc(1'b0, '0, '0, 1'b1, 32'h00900000, 1'b0);
        rst_n = 1'b0;
        #1;
        chk("R1 reset clears output", 1'b0, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        look("R1 miss after reset", 32'h00900000, 1'b0, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule